// File: doc/BRIEF.md
# DMA Peripheral Request Router

This block sits beside one DMA channel and turns an on-chip peripheral interrupt into that channel's transfer request. A 4-bit source code picks one of six peripheral lines: infrared transmit-empty, infrared receive-full, serial FIFO transmit-empty, serial FIFO receive-full, converter-done and timer compare-match. The router notes the rising edge of that line, once the peripheral's own interrupt enable qualifies it, and holds a request. It shows the request to the DMA engine only while the channel and controller permissions allow it.

The held request is dropped when the engine reports a completed transfer. In cycle-steal mode this happens on the first completion. In burst mode it waits for the completion flagged as the last one. Five of the sources may run only in cycle-steal mode. Pairing one of them with burst mode raises an error flag and blocks the request. While a line is claimed for DMA, its interrupt to the CPU is masked. All other qualified lines pass through unchanged.

Top module: `dma_req_router`

## Requirements
- R1: After a synchronous active-low reset the held request is clear, so `dmaReq` is 0 until a new rising edge is captured.
- R2: Source codes 4'hA, 4'hB, 4'hC, 4'hD, 4'hE and 4'hF select line bits 0 to 5 of `periphIrq` (infrared TX, infrared RX, serial TX, serial RX, converter, timer). Any other code selects nothing: no request, no error, and no masking.
- R3: `dmaReq` is 1 only while a request is held and `chanEn`=1, `masterEn`=1, `endFlag`=0, `addrErrFlag`=0 and `nmiFlag`=0. Dropping a permission hides the held request without discarding it.
- R4: A line whose bit in `periphIe` is 0 is never captured as a request.
- R5: A 0-to-1 change of the selected qualified line, seen at a clock edge, sets the held request, and `dmaReq` shows it from the next cycle. A line that stays high does not capture again.
- R6: With `burstMode`=0, a `xferDone` pulse clears the held request at that edge.
- R7: With `burstMode`=1, `xferDone` clears the held request only when `lastXfer`=1. Without it the request is kept.
- R8: With `burstMode`=1 and codes 4'hA to 4'hE, `modeErr` is 1, no edge is captured and `dmaReq` is 0. Code 4'hF is legal in both modes.
- R9: `cpuIrq` equals `periphIrq & periphIe`, except that the bit of the currently selected source is forced to 0.
- R10: A change of the source code between two clock edges discards the held request.
- R11: When a capture and a clear fall on the same edge, the capture wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| resSel | input | 4 | Source code for the channel |
| chanEn | input | 1 | Channel enable |
| masterEn | input | 1 | Controller-wide DMA enable |
| endFlag | input | 1 | Channel transfer-end status |
| addrErrFlag | input | 1 | Address-error status |
| nmiFlag | input | 1 | Non-maskable-interrupt status |
| burstMode | input | 1 | 1 = burst, 0 = cycle-steal |
| xferDone | input | 1 | One-cycle strobe per completed transfer |
| lastXfer | input | 1 | Qualifies `xferDone` as the final transfer |
| periphIrq | input | 6 | Raw peripheral interrupt lines |
| periphIe | input | 6 | Per-peripheral interrupt enables |
| dmaReq | output | 1 | Transfer request to the DMA engine |
| modeErr | output | 1 | Illegal source/mode pairing |
| cpuIrq | output | 6 | Interrupt lines forwarded to the CPU |

## Verification
The properties assume that `xferDone` and `lastXfer` are level samples taken at each clock edge. They also assume that `burstMode` and `resSel` during a completion cycle describe the transfer that just finished, so a clear is judged on the mode present at that edge. The stimulus changes every input only at the falling clock edge. It draws source codes with a bias toward the six valid ones, keeps the permission bits mostly set, and pulses completion strobes at random. This holds the random run within those assumptions while still reaching every path that clears, masks and reports errors.

// File: rtl/dma_req_pkg.sv
package dma_req_pkg;

  // Number of selectable peripheral lines and width of the source code
  localparam int NUM_SRC  = 6;
  localparam int SEL_W    = 4;
  // Code that selects line 0; lines follow consecutively
  localparam int SEL_BASE = 10;
  // Lines that may be used with burst mode (timer only)
  localparam logic [NUM_SRC-1:0] BURST_OK = 6'b10_0000;

  // Strobes from control to datapath for the held request
  typedef struct packed {
    logic capture;   // set the held request
    logic release_;  // completion clears it
    logic flush;     // selection changed, discard it
  } reqStrobeT;

endpackage

// File: rtl/dma_req_ctrl.sv
module dma_req_ctrl
  import dma_req_pkg::*;
#(
  parameter int NSRC = NUM_SRC,
  parameter int SW   = SEL_W,
  parameter int BASE = SEL_BASE,
  parameter logic [NSRC-1:0] BURST_MASK = BURST_OK
) (
  input  logic [SW-1:0]   resSel,
  input  logic [SW-1:0]   prevSel,
  input  logic            chanEn,
  input  logic            masterEn,
  input  logic            endFlag,
  input  logic            addrErrFlag,
  input  logic            nmiFlag,
  input  logic            burstMode,
  input  logic            xferDone,
  input  logic            lastXfer,
  input  logic [NSRC-1:0] riseLines,
  output logic [NSRC-1:0] selOneHot,
  output logic            selValid,
  output logic            chanGate,
  output logic            modeErr,
  output reqStrobeT       strobes
);

  logic burstLegal;
  logic selRise;

  // Source decode: one comparator per line
  for (genvar gi = 0; gi < NSRC; gi++) begin : g_decode
    assign selOneHot[gi] = (resSel == SW'(BASE + gi));
  end

  assign selValid   = |selOneHot;
  assign burstLegal = |(selOneHot & BURST_MASK);
  assign modeErr    = selValid & burstMode & ~burstLegal;

  // Channel permission: enables set and no stopping status
  assign chanGate = chanEn & masterEn & ~endFlag & ~addrErrFlag & ~nmiFlag;

  assign selRise = |(selOneHot & riseLines);

  always_comb begin
    strobes          = '0;
    strobes.capture  = selRise & ~modeErr;
    strobes.release_ = xferDone & (~burstMode | lastXfer);
    strobes.flush    = (resSel != prevSel);
  end

endmodule

// File: rtl/dma_req_datapath.sv
module dma_req_datapath
  import dma_req_pkg::*;
#(
  parameter int NSRC = NUM_SRC,
  parameter int SW   = SEL_W
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [SW-1:0]   resSel,
  input  logic [NSRC-1:0] periphIrq,
  input  logic [NSRC-1:0] periphIe,
  input  logic [NSRC-1:0] selOneHot,
  input  logic            selValid,
  input  logic            chanGate,
  input  logic            modeErr,
  input  reqStrobeT       strobes,
  output logic [NSRC-1:0] riseLines,
  output logic [SW-1:0]   prevSel,
  output logic            dmaReq,
  output logic [NSRC-1:0] cpuIrq
);

  logic [NSRC-1:0] qualLines;
  logic [NSRC-1:0] prevLines;
  logic            reqHeld;
  logic            reqNext;

  assign qualLines = periphIrq & periphIe;
  assign riseLines = qualLines & ~prevLines;

  // Per-line CPU forwarding with the claimed line masked
  for (genvar gi = 0; gi < NSRC; gi++) begin : g_cpu
    assign cpuIrq[gi] = qualLines[gi] & ~selOneHot[gi];
  end

  always_comb begin
    reqNext = reqHeld;
    if (strobes.capture)
      reqNext = 1'b1;
    else if (strobes.release_ || strobes.flush)
      reqNext = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqHeld   <= 1'b0;
      prevLines <= '0;
      prevSel   <= '0;
    end else begin
      reqHeld   <= reqNext;
      prevLines <= qualLines;
      prevSel   <= resSel;
    end
  end

  assign dmaReq = reqHeld & chanGate & selValid & ~modeErr;

endmodule

// File: rtl/dma_req_router.sv
module dma_req_router
  import dma_req_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [SEL_W-1:0]   resSel,
  input  logic               chanEn,
  input  logic               masterEn,
  input  logic               endFlag,
  input  logic               addrErrFlag,
  input  logic               nmiFlag,
  input  logic               burstMode,
  input  logic               xferDone,
  input  logic               lastXfer,
  input  logic [NUM_SRC-1:0] periphIrq,
  input  logic [NUM_SRC-1:0] periphIe,
  output logic               dmaReq,
  output logic               modeErr,
  output logic [NUM_SRC-1:0] cpuIrq
);

  logic [NUM_SRC-1:0] selOneHot;
  logic [NUM_SRC-1:0] riseLines;
  logic [SEL_W-1:0]   prevSel;
  logic               selValid;
  logic               chanGate;
  reqStrobeT          strobes;

  dma_req_ctrl #(
    .NSRC(NUM_SRC), .SW(SEL_W), .BASE(SEL_BASE), .BURST_MASK(BURST_OK)
  ) i_ctrl (
    .resSel     (resSel),
    .prevSel    (prevSel),
    .chanEn     (chanEn),
    .masterEn   (masterEn),
    .endFlag    (endFlag),
    .addrErrFlag(addrErrFlag),
    .nmiFlag    (nmiFlag),
    .burstMode  (burstMode),
    .xferDone   (xferDone),
    .lastXfer   (lastXfer),
    .riseLines  (riseLines),
    .selOneHot  (selOneHot),
    .selValid   (selValid),
    .chanGate   (chanGate),
    .modeErr    (modeErr),
    .strobes    (strobes)
  );

  dma_req_datapath #(
    .NSRC(NUM_SRC), .SW(SEL_W)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .resSel   (resSel),
    .periphIrq(periphIrq),
    .periphIe (periphIe),
    .selOneHot(selOneHot),
    .selValid (selValid),
    .chanGate (chanGate),
    .modeErr  (modeErr),
    .strobes  (strobes),
    .riseLines(riseLines),
    .prevSel  (prevSel),
    .dmaReq   (dmaReq),
    .cpuIrq   (cpuIrq)
  );

endmodule

// File: rtl/dma_req_router_chk.sv
module dma_req_router_chk
  import dma_req_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic [SEL_W-1:0]   resSel,
  input logic               chanEn,
  input logic               masterEn,
  input logic               endFlag,
  input logic               addrErrFlag,
  input logic               nmiFlag,
  input logic               burstMode,
  input logic               xferDone,
  input logic               lastXfer,
  input logic [NUM_SRC-1:0] periphIrq,
  input logic [NUM_SRC-1:0] periphIe,
  input logic               dmaReq,
  input logic               modeErr,
  input logic [NUM_SRC-1:0] cpuIrq
);

  logic inRange;
  logic selQual;

  assign inRange = (resSel >= SEL_W'(SEL_BASE)) &&
                   (resSel <= SEL_W'(SEL_BASE + NUM_SRC - 1));

  always_comb begin
    selQual = 1'b0;
    for (int i = 0; i < NUM_SRC; i++)
      if (resSel == SEL_W'(SEL_BASE + i))
        selQual = periphIrq[i] & periphIe[i];
  end

  // R3
  perm_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    dmaReq |-> (chanEn && masterEn && !endFlag && !addrErrFlag && !nmiFlag));

  // R8
  err_blocks_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    modeErr |-> !dmaReq);

  // R2
  no_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inRange |-> (!dmaReq && !modeErr && cpuIrq == (periphIrq & periphIe)));

  // R9
  cpu_qual_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuIrq & ~(periphIrq & periphIe)) == '0);

  // R6
  steal_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (xferDone && !burstMode && !selQual) |=> !dmaReq);

endmodule

bind dma_req_router dma_req_router_chk i_chk (.*);

// File: tb/test_dma_req_router.sv
`timescale 1ns/1ps
module test_dma_req_router;

  logic       clk = 1'b0;
  logic       rstN;
  logic [3:0] resSel;
  logic       chanEn, masterEn, endFlag, addrErrFlag, nmiFlag;
  logic       burstMode, xferDone, lastXfer;
  logic [5:0] periphIrq, periphIe;
  logic       dmaReq, modeErr;
  logic [5:0] cpuIrq;

  int vectors = 0;
  int fails   = 0;

  // Reference state
  logic       mReq;
  logic [5:0] mPrev;
  logic [3:0] mPrevSel;

  always #2 clk = ~clk;

  dma_req_router i_dma_req_router (.*);

  task automatic cmp(string tag, string what, int got, int exp);
    vectors++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  // Called at a falling edge with inputs already driven
  task automatic stepChk(string tag, bit doCheck = 1'b1);
    logic       valid, err, gate, cap, rel, fl, expReq;
    logic [5:0] qual, selMask, expCpu;
    int         idx;
    #1;
    valid   = (resSel >= 4'hA);
    idx     = valid ? int'(resSel) - 10 : 0;
    selMask = valid ? (6'b1 << idx) : 6'b0;
    err     = valid && burstMode && (idx != 5);
    gate    = chanEn && masterEn && !endFlag && !addrErrFlag && !nmiFlag;
    qual    = periphIrq & periphIe;
    expReq  = mReq && gate && valid && !err;
    expCpu  = qual & ~selMask;
    if (doCheck) begin
      cmp(tag, "dmaReq", int'(dmaReq), int'(expReq));
      cmp(tag, "modeErr", int'(modeErr), int'(err));
      cmp(tag, "cpuIrq", int'(cpuIrq), int'(expCpu));
    end
    cap = valid && qual[idx] && !mPrev[idx] && !err;
    rel = xferDone && (!burstMode || lastXfer);
    fl  = (resSel != mPrevSel);
    if (!rstN) begin
      mReq = 1'b0; mPrev = '0; mPrevSel = '0;
    end else begin
      mReq     = cap ? 1'b1 : ((rel || fl) ? 1'b0 : mReq);
      mPrev    = qual;
      mPrevSel = resSel;
    end
    @(negedge clk);
  endtask

  task automatic idle();
    xferDone = 1'b0; lastXfer = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    mReq = 1'b0; mPrev = '0; mPrevSel = '0;
    rstN = 1'b0; resSel = 4'hF;
    chanEn = 1'b1; masterEn = 1'b1; endFlag = 1'b0; addrErrFlag = 1'b0; nmiFlag = 1'b0;
    burstMode = 1'b0; xferDone = 1'b0; lastXfer = 1'b0;
    periphIrq = '0; periphIe = 6'h3F;
    @(negedge clk);
    repeat (3) stepChk("reset", 1'b0);
    rstN = 1'b1;
    // R1: nothing held after reset
    stepChk("R1");
    stepChk("R1");

    // R5: rising edge on timer line captures, steady high does not recapture
    periphIrq[5] = 1'b1; stepChk("R5");
    stepChk("R5");
    // R6: cycle-steal completion clears
    xferDone = 1'b1; stepChk("R6");
    idle(); stepChk("R6");
    stepChk("R5");

    // R7: burst holds until the last completion
    burstMode = 1'b1; periphIrq[5] = 1'b0; stepChk("R7");
    periphIrq[5] = 1'b1; stepChk("R7");
    xferDone = 1'b1; stepChk("R7");
    stepChk("R7");
    lastXfer = 1'b1; stepChk("R7");
    idle(); stepChk("R7");
    stepChk("R7");

    // R3: each permission hides the held request
    burstMode = 1'b0; periphIrq[5] = 1'b0; stepChk("R3");
    periphIrq[5] = 1'b1; stepChk("R3");
    chanEn = 1'b0; stepChk("R3"); chanEn = 1'b1; stepChk("R3");
    masterEn = 1'b0; stepChk("R3"); masterEn = 1'b1; stepChk("R3");
    endFlag = 1'b1; stepChk("R3"); endFlag = 1'b0; stepChk("R3");
    addrErrFlag = 1'b1; stepChk("R3"); addrErrFlag = 1'b0; stepChk("R3");
    nmiFlag = 1'b1; stepChk("R3"); nmiFlag = 1'b0; stepChk("R3");

    // R11: capture and clear on the same edge
    periphIrq[5] = 1'b0; stepChk("R11");
    periphIrq[5] = 1'b1; xferDone = 1'b1; stepChk("R11");
    idle(); stepChk("R11");

    // R10: changing the source discards the held request
    resSel = 4'hE; stepChk("R10");
    resSel = 4'hF; stepChk("R10");
    stepChk("R10");

    // R8: cycle-steal-only source in burst mode
    resSel = 4'hC; burstMode = 1'b1; periphIrq = 6'b000000; stepChk("R8");
    periphIrq[2] = 1'b1; stepChk("R8");
    stepChk("R8");
    burstMode = 1'b0; stepChk("R8");
    periphIrq[2] = 1'b0; stepChk("R8");
    periphIrq[2] = 1'b1; stepChk("R8");
    stepChk("R8");

    // R4: disabled line ignored, enabling it while high acts as an edge
    resSel = 4'hA; periphIrq = '0; stepChk("R4");
    periphIe[0] = 1'b0; periphIrq[0] = 1'b1; stepChk("R4");
    stepChk("R4");
    periphIe[0] = 1'b1; stepChk("R4");
    stepChk("R4");

    // R9: all lines high, each selection masks its own bit
    periphIrq = 6'h3F;
    for (int c = 10; c < 16; c++) begin
      resSel = 4'(c); stepChk("R9");
    end
    periphIe = 6'b101010; stepChk("R9");
    periphIe = 6'h3F;

    // R2: codes outside the table select nothing
    resSel = 4'h3; periphIrq = '0; stepChk("R2");
    periphIrq = 6'h3F; burstMode = 1'b1; stepChk("R2");
    resSel = 4'h9; stepChk("R2");
    resSel = 4'h0; burstMode = 1'b0; stepChk("R2");

    // Random mix: R2 R3 R5 R6 R7 R8 R9 R10
    for (int n = 0; n < 3000; n++) begin
      resSel      = ($urandom_range(0, 7) == 0) ? 4'($urandom_range(0, 9))
                                                 : 4'($urandom_range(10, 15));
      if ($urandom_range(0, 3) != 0) resSel = mPrevSel;
      chanEn      = ($urandom_range(0, 9) != 0);
      masterEn    = ($urandom_range(0, 9) != 0);
      endFlag     = ($urandom_range(0, 14) == 0);
      addrErrFlag = ($urandom_range(0, 14) == 0);
      nmiFlag     = ($urandom_range(0, 14) == 0);
      burstMode   = ($urandom_range(0, 2) == 0);
      xferDone    = ($urandom_range(0, 3) == 0);
      lastXfer    = ($urandom_range(0, 2) == 0);
      periphIrq   = 6'($urandom);
      periphIe    = 6'($urandom) | 6'($urandom);
      stepChk("random R2 R3 R5 R7 R9");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule